// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of a 16-bit parallel NOR flash bus and turns a single request (program one word, erase one sector, or erase one block) into the full series of bus write cycles the flash expects. It then reads the flash status until the internal operation finishes. A request carries an operation code, a word address, a data word and a write-protect level. It is accepted in one clock through a start/busy handshake. The block answers with a one-clock `done` pulse or a one-clock `timeout_err` pulse.

Each bus cycle is built from registered strobes. Chip enable falls first. Write enable (or output enable for a status read) falls after a programmable setup time and stays low for a programmable strobe width. Both strobes then rise together, and address and data stay driven for a programmable hold time. Completion is found by toggle polling: status reads go to the target address until two reads in a row return the same value on status bit 6. A poll limit ends the wait with an error. An abort input pulses the flash reset line for a fixed number of clocks and returns the sequencer to idle.

Top module: `nor_op_sequencer`

## Requirements
- R1: While and after synchronous reset, `busy`, `done` and `timeout_err` are 0. `flash_ce_n`, `flash_we_n`, `flash_oe_n` and `flash_rst_n` are 1, and `flash_dq_oe` is 0.
- R2: In every bus write, `flash_ce_n` is low for exactly SETUP_CLKS clocks before `flash_we_n` falls, and `flash_we_n` stays low for exactly WE_CLKS clocks. `flash_we_n` is never low while `flash_ce_n` is high or while `flash_oe_n` is low.
- R3: `flash_addr` and `flash_dq_o` do not change and `flash_dq_oe` stays 1 while `flash_we_n` is low. After `flash_we_n` rises, they stay driven and unchanged for exactly HOLD_CLKS clocks.
- R4: A program request (`req_op` = 0) issues exactly four writes in this order: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`req_addr`, `req_data`).
- R5: A sector erase (`req_op` = 1) or block erase (`req_op` = 2) issues exactly six writes in this order: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then a final write. For a sector erase the final write is `req_addr` with bits [10:0] cleared and data 30h. For a block erase it is `req_addr` with bits [14:0] cleared and data 50h.
- R6: After the last write, only status reads are made at the request address, each with `flash_oe_n` low for exactly OE_CLKS clocks. When two consecutive reads return equal bit 6, `done` pulses for one clock, `busy` is 0 in that same clock, and no other data bit affects the result.
- R7: If MAX_POLLS status reads complete without two consecutive equal bit-6 values, `timeout_err` pulses for one clock instead of `done`, and `busy` returns to 0.
- R8: `flash_wp_n` takes the value of `req_wp_n` when a request is accepted and does not change while `busy` is 1.
- R9: A request is accepted only while `busy` is 0, and `busy` is 1 in the clock after acceptance. `req_valid` pulses while busy start nothing, and changes to `req_wp_n` made while busy have no effect.
- R10: One clock after `abort` is sampled high, `flash_rst_n` is 0 and the bus is released (`flash_ce_n`, `flash_we_n`, `flash_oe_n` high, `flash_dq_oe` 0). `flash_rst_n` stays low for exactly RST_CLKS clocks, then `busy` is 0, and neither `done` nor `timeout_err` pulses for that aborted request.
- R11: A request with `req_op` = 3 is not accepted: `busy` stays 0 and no bus cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start pulse for a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 reserved |
| req_addr | input | AW | Word address of the request |
| req_data | input | DW | Word to program |
| req_wp_n | input | 1 | Write-protect level to hold during the request |
| abort | input | 1 | Abandon the request and pulse the flash reset |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock pulse on completion |
| timeout_err | output | 1 | One-clock pulse when the poll limit is reached |
| flash_addr | output | AW | Flash address bus |
| flash_dq_o | output | DW | Data driven toward the flash |
| flash_dq_oe | output | 1 | Drive enable for `flash_dq_o` |
| flash_dq_i | input | DW | Data read from the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_rst_n | output | 1 | Flash reset, active low |
| flash_wp_n | output | 1 | Write protect, active low |

## Verification
The embedded properties assume that `req_valid` and `abort` are synchronous to `clk`. They also assume that `flash_dq_i` does not change while `flash_oe_n` is low, because the strobe checks and the poll comparison depend on one stable sample per read. The bench drives every input only at falling clock edges. Its flash model changes the status word only after output enable rises, and flips bit 6 a chosen number of times per request while the other bits take fresh random values on each read. The bench mixes random requests from a fixed seed with directed abort, reserved-code and start-while-busy cases.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_RSVD = 2'd3
  } nor_op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } nor_phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_POLL_ISSUE,
    S_POLL_WAIT,
    S_RESET
  } nor_state_e;

endpackage

// File: rtl/nor_cmd_script.sv
module nor_cmd_script
  import nor_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int SECTOR_LSB = 11,
  parameter int BLOCK_LSB  = 15,
  parameter logic [AW-1:0] UNLOCK_A = 'h5555,
  parameter logic [AW-1:0] UNLOCK_B = 'h2AAA
) (
  input  nor_op_e         op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   base_addr,
  input  logic [DW-1:0]   word,
  output logic [AW-1:0]   cyc_addr,
  output logic [DW-1:0]   cyc_data,
  output logic            last_step
);

  localparam logic [AW-1:0] SECT_MASK = {{(AW-SECTOR_LSB){1'b1}}, {SECTOR_LSB{1'b0}}};
  localparam logic [AW-1:0] BLK_MASK  = {{(AW-BLOCK_LSB){1'b1}}, {BLOCK_LSB{1'b0}}};

  always_comb begin
    cyc_addr  = UNLOCK_A;
    cyc_data  = DW'(8'hAA);
    last_step = 1'b0;
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin cyc_addr = UNLOCK_A; cyc_data = DW'(8'hAA); end
        3'd1: begin cyc_addr = UNLOCK_B; cyc_data = DW'(8'h55); end
        3'd2: begin cyc_addr = UNLOCK_A; cyc_data = DW'(8'hA0); end
        default: begin
          cyc_addr  = base_addr;
          cyc_data  = word;
          last_step = 1'b1;
        end
      endcase
    end else begin
      case (step)
        3'd0: begin cyc_addr = UNLOCK_A; cyc_data = DW'(8'hAA); end
        3'd1: begin cyc_addr = UNLOCK_B; cyc_data = DW'(8'h55); end
        3'd2: begin cyc_addr = UNLOCK_A; cyc_data = DW'(8'h80); end
        3'd3: begin cyc_addr = UNLOCK_A; cyc_data = DW'(8'hAA); end
        3'd4: begin cyc_addr = UNLOCK_B; cyc_data = DW'(8'h55); end
        default: begin
          last_step = 1'b1;
          if (op == OP_SECT) begin
            cyc_addr = base_addr & SECT_MASK;
            cyc_data = DW'(8'h30);
          end else begin
            cyc_addr = base_addr & BLK_MASK;
            cyc_data = DW'(8'h50);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int SETUP_CLKS = 2,
  parameter int WE_CLKS    = 4,
  parameter int OE_CLKS    = 4,
  parameter int HOLD_CLKS  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kill,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          cyc_done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe,
  input  logic [DW-1:0] bus_dq_i,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n
);

  localparam int M1   = (SETUP_CLKS > WE_CLKS) ? SETUP_CLKS : WE_CLKS;
  localparam int M2   = (OE_CLKS > HOLD_CLKS) ? OE_CLKS : HOLD_CLKS;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  nor_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic          is_wr_q;
  logic [CW-1:0] strobe_last;

  assign strobe_last = is_wr_q ? CW'(WE_CLKS - 1) : CW'(OE_CLKS - 1);

  always_ff @(posedge clk) begin
    cyc_done <= 1'b0;
    if (rst || kill) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      bus_ce_n  <= 1'b1;
      bus_we_n  <= 1'b1;
      bus_oe_n  <= 1'b1;
      bus_dq_oe <= 1'b0;
      if (rst) begin
        bus_addr <= '0;
        bus_dq_o <= '0;
        rd_data  <= '0;
        is_wr_q  <= 1'b0;
      end
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (cmd_valid) begin
            phase_q   <= PH_SETUP;
            cnt_q     <= '0;
            bus_addr  <= cmd_addr;
            bus_dq_o  <= cmd_data;
            bus_dq_oe <= cmd_write;
            is_wr_q   <= cmd_write;
            bus_ce_n  <= 1'b0;
          end
        end
        PH_SETUP: begin
          if (cnt_q == CW'(SETUP_CLKS - 1)) begin
            cnt_q   <= '0;
            phase_q <= PH_STROBE;
            if (is_wr_q) bus_we_n <= 1'b0;
            else         bus_oe_n <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_q == strobe_last) begin
            cnt_q    <= '0;
            phase_q  <= PH_HOLD;
            bus_we_n <= 1'b1;
            bus_oe_n <= 1'b1;
            bus_ce_n <= 1'b1;
            if (!is_wr_q) rd_data <= bus_dq_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == CW'(HOLD_CLKS - 1)) begin
            cnt_q     <= '0;
            phase_q   <= PH_IDLE;
            bus_dq_oe <= 1'b0;
            cyc_done  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R2: write strobe only inside chip enable, never overlapping a read strobe
  a_r2_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> !bus_ce_n);
  a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(!bus_we_n && !bus_oe_n));
  // R3: address and data frozen and driven across the write strobe
  a_r3_stable_under_we: assert property (@(posedge clk) disable iff (rst)
    (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_dq_o) && bus_dq_oe));

endmodule

// File: rtl/nor_poll_track.sv
module nor_poll_track #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sample_valid,
  input  logic sample_bit,
  output logic settled,
  output logic expired
);

  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt_q;
  logic          have_prev_q;
  logic          prev_q;

  assign settled = sample_valid && have_prev_q && (sample_bit == prev_q);
  assign expired = sample_valid && !settled && (cnt_q == CW'(MAX_POLLS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q       <= '0;
      have_prev_q <= 1'b0;
      prev_q      <= 1'b0;
    end else if (sample_valid) begin
      cnt_q       <= cnt_q + 1'b1;
      have_prev_q <= 1'b1;
      prev_q      <= sample_bit;
    end
  end

  // R7: the poll count never passes the limit
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAX_POLLS));

endmodule

// File: rtl/nor_op_sequencer.sv
module nor_op_sequencer
  import nor_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int SETUP_CLKS = 2,
  parameter int WE_CLKS    = 4,
  parameter int OE_CLKS    = 4,
  parameter int HOLD_CLKS  = 2,
  parameter int RST_CLKS   = 8,
  parameter int MAX_POLLS  = 4096,
  parameter int SECTOR_LSB = 11,
  parameter int BLOCK_LSB  = 15,
  parameter int STATUS_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_wp_n,
  input  logic          abort,
  output logic          busy,
  output logic          done,
  output logic          timeout_err,
  output logic [AW-1:0] flash_addr,
  output logic [DW-1:0] flash_dq_o,
  output logic          flash_dq_oe,
  input  logic [DW-1:0] flash_dq_i,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n,
  output logic          flash_rst_n,
  output logic          flash_wp_n
);

  localparam int RW = $clog2(RST_CLKS + 1);

  nor_state_e    state_q;
  nor_op_e       op_q;
  logic [2:0]    step_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [RW-1:0] rcnt_q;
  logic          cmd_valid_q;
  logic          cmd_write_q;
  logic [AW-1:0] cmd_addr_q;
  logic [DW-1:0] cmd_data_q;
  logic          accept;

  logic [AW-1:0] scr_addr;
  logic [DW-1:0] scr_data;
  logic          scr_last;
  logic          cyc_done;
  logic [DW-1:0] rd_data;
  logic          poll_sample;
  logic          poll_settled;
  logic          poll_expired;

  assign accept      = (state_q == S_IDLE) && req_valid && (req_op != OP_RSVD);
  assign poll_sample = cyc_done && (state_q == S_POLL_WAIT);
  assign busy        = (state_q != S_IDLE);

  nor_cmd_script #(
    .AW(AW), .DW(DW), .SECTOR_LSB(SECTOR_LSB), .BLOCK_LSB(BLOCK_LSB)
  ) u_script (
    .op(op_q), .step(step_q), .base_addr(addr_q), .word(data_q),
    .cyc_addr(scr_addr), .cyc_data(scr_data), .last_step(scr_last)
  );

  nor_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_CLKS(SETUP_CLKS), .WE_CLKS(WE_CLKS),
    .OE_CLKS(OE_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) u_bus (
    .clk(clk), .rst(rst), .kill(abort),
    .cmd_valid(cmd_valid_q), .cmd_write(cmd_write_q),
    .cmd_addr(cmd_addr_q), .cmd_data(cmd_data_q),
    .cyc_done(cyc_done), .rd_data(rd_data),
    .bus_addr(flash_addr), .bus_dq_o(flash_dq_o), .bus_dq_oe(flash_dq_oe),
    .bus_dq_i(flash_dq_i), .bus_ce_n(flash_ce_n), .bus_we_n(flash_we_n),
    .bus_oe_n(flash_oe_n)
  );

  nor_poll_track #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst(rst), .clear(accept),
    .sample_valid(poll_sample), .sample_bit(rd_data[STATUS_BIT]),
    .settled(poll_settled), .expired(poll_expired)
  );

  always_ff @(posedge clk) begin
    cmd_valid_q <= 1'b0;
    done        <= 1'b0;
    timeout_err <= 1'b0;
    if (rst) begin
      state_q     <= S_IDLE;
      op_q        <= OP_PROG;
      step_q      <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      rcnt_q      <= '0;
      cmd_write_q <= 1'b0;
      cmd_addr_q  <= '0;
      cmd_data_q  <= '0;
      flash_rst_n <= 1'b1;
      flash_wp_n  <= 1'b1;
    end else if (abort) begin
      state_q     <= S_RESET;
      rcnt_q      <= '0;
      flash_rst_n <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            op_q       <= nor_op_e'(req_op);
            addr_q     <= req_addr;
            data_q     <= req_data;
            flash_wp_n <= req_wp_n;
            step_q     <= '0;
            state_q    <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          cmd_valid_q <= 1'b1;
          cmd_write_q <= 1'b1;
          cmd_addr_q  <= scr_addr;
          cmd_data_q  <= scr_data;
          state_q     <= S_WAIT;
        end
        S_WAIT: begin
          if (cyc_done) begin
            if (scr_last) begin
              state_q <= S_POLL_ISSUE;
            end else begin
              step_q  <= step_q + 3'd1;
              state_q <= S_ISSUE;
            end
          end
        end
        S_POLL_ISSUE: begin
          cmd_valid_q <= 1'b1;
          cmd_write_q <= 1'b0;
          cmd_addr_q  <= addr_q;
          state_q     <= S_POLL_WAIT;
        end
        S_POLL_WAIT: begin
          if (cyc_done) begin
            if (poll_settled) begin
              done    <= 1'b1;
              state_q <= S_IDLE;
            end else if (poll_expired) begin
              timeout_err <= 1'b1;
              state_q     <= S_IDLE;
            end else begin
              state_q <= S_POLL_ISSUE;
            end
          end
        end
        default: begin
          if (rcnt_q == RW'(RST_CLKS - 1)) begin
            flash_rst_n <= 1'b1;
            state_q     <= S_IDLE;
          end else begin
            rcnt_q <= rcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R8: protect level held for the whole request
  a_r8_wp_static: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(flash_wp_n));
  // R6: no write strobe once status polling has begun
  a_r6_no_write_in_poll: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_POLL_ISSUE || state_q == S_POLL_WAIT) |-> flash_we_n);
  // R6: completion reported together with leaving busy
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: never both outcomes
  a_r7_outcome_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout_err));
  // R10: bus released while the flash is held in reset
  a_r10_reset_releases_bus: assert property (@(posedge clk) disable iff (rst)
    !flash_rst_n |-> (flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe));
  // R9: a start while busy does not alter the latched request
  a_r9_hold_request: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(op_q)));

endmodule

// File: tb/nor_op_sequencer_bench.sv
`timescale 1ns/1ps
module nor_op_sequencer_bench;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int T_SU = 2;
  localparam int T_WE = 3;
  localparam int T_OE = 2;
  localparam int T_HD = 2;
  localparam int T_RST = 4;
  localparam int MAXP = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_wp_n = 1'b1;
  logic abort = 1'b0;
  logic busy, done, timeout_err;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_dq_o;
  logic flash_dq_oe;
  logic [DW-1:0] flash_dq_i;
  logic flash_ce_n, flash_we_n, flash_oe_n, flash_rst_n, flash_wp_n;

  always #2.5 clk = ~clk;

  nor_op_sequencer #(
    .AW(AW), .DW(DW), .SETUP_CLKS(T_SU), .WE_CLKS(T_WE), .OE_CLKS(T_OE),
    .HOLD_CLKS(T_HD), .RST_CLKS(T_RST), .MAX_POLLS(MAXP)
  ) u_nor_op_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_wp_n(req_wp_n),
    .abort(abort), .busy(busy), .done(done), .timeout_err(timeout_err),
    .flash_addr(flash_addr), .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
    .flash_dq_i(flash_dq_i), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
    .flash_oe_n(flash_oe_n), .flash_rst_n(flash_rst_n), .flash_wp_n(flash_wp_n)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash status model
  int toggles_left = 0;
  logic dq6 = 1'b0;
  logic [15:0] noise = 16'h1234;
  logic m_prev_oe = 1'b1;
  assign flash_dq_i = {noise[15:7], dq6, noise[5:0]};

  always @(negedge clk) begin
    if (!m_prev_oe && flash_oe_n) begin
      if (toggles_left > 0) begin
        dq6 = ~dq6;
        toggles_left--;
      end
      noise = 16'($urandom);
    end
    m_prev_oe = flash_oe_n;
  end

  // bus monitor
  logic [AW-1:0] wa [16];
  logic [DW-1:0] wd [16];
  int wr_cnt = 0, rd_cnt = 0;
  int su = 0, wl = 0, hd = 0, ol = 0;
  bit hd_on = 0, stab = 1, timing_on = 1, wp_bad = 0;
  logic exp_wp = 1'b1;
  logic [AW-1:0] ra;
  logic [DW-1:0] rdq;
  logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_ce && !flash_ce_n) su = 1;
      else if (!flash_ce_n && flash_we_n && flash_oe_n) su++;
      if (p_we && !flash_we_n) begin
        if (timing_on) check(su == T_SU, "R2 setup clocks", su, T_SU);
        if (wr_cnt < 16) begin
          wa[wr_cnt] = flash_addr;
          wd[wr_cnt] = flash_dq_o;
        end
        ra = flash_addr; rdq = flash_dq_o;
        wr_cnt++; wl = 1; stab = flash_dq_oe;
      end else if (!flash_we_n) begin
        wl++;
        if (flash_addr != ra || flash_dq_o != rdq || !flash_dq_oe) stab = 0;
      end
      if (!p_we && flash_we_n) begin
        if (timing_on) begin
          check(wl == T_WE, "R2 we width", wl, T_WE);
          check(stab, "R3 stable under we", stab, 1);
        end
        hd = flash_dq_oe ? 1 : 0; hd_on = 1;
      end else if (hd_on) begin
        if (flash_dq_oe && flash_addr == ra && flash_dq_o == rdq) hd++;
        else begin
          hd_on = 0;
          if (timing_on) check(hd == T_HD, "R3 hold clocks", hd, T_HD);
        end
      end
      if (p_oe && !flash_oe_n) begin rd_cnt++; ol = 1; end
      else if (!flash_oe_n) ol++;
      if (!p_oe && flash_oe_n && timing_on) check(ol == T_OE, "R6 oe width", ol, T_OE);
      if (!flash_we_n && (flash_ce_n || !flash_oe_n)) check(0, "R2 strobe overlap", 1, 0);
      if (busy && flash_wp_n !== exp_wp) wp_bad = 1;
    end
    p_ce = flash_ce_n; p_we = flash_we_n; p_oe = flash_oe_n;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [AW-1:0] exp_addr(input logic [1:0] op, input logic [AW-1:0] a, input int i);
    logic [AW-1:0] u1 = 21'h5555, u2 = 21'h2AAA;
    if (op == 2'd0) return (i == 0 || i == 2) ? u1 : (i == 1) ? u2 : a;
    case (i)
      0, 2, 3: return u1;
      1, 4:    return u2;
      default: return (op == 2'd1) ? (a & ~21'h7FF) : (a & ~21'h7FFF);
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [1:0] op, input logic [DW-1:0] d, input int i);
    if (op == 2'd0) return (i == 0) ? 16'hAA : (i == 1) ? 16'h55 : (i == 2) ? 16'hA0 : d;
    case (i)
      0, 3: return 16'hAA;
      1, 4: return 16'h55;
      2:    return 16'h80;
      default: return (op == 2'd1) ? 16'h30 : 16'h50;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic wp, input int k, input bit poke);
    int n;
    int nw;
    bit exp_done;
    bit got_done, got_tmo;
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; toggles_left = k; exp_wp = wp; wp_bad = 0;
    req_op = op; req_addr = a; req_data = d; req_wp_n = wp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R9 accepted when idle", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      req_op = (op == 2'd0) ? 2'd2 : 2'd0; req_addr = ~a; req_wp_n = ~wp; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!(done || timeout_err) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    got_done = done; got_tmo = timeout_err;
    exp_done = (k + 2 <= MAXP);
    check(busy == 1'b0, "R6 busy low with outcome", busy, 0);
    check(got_done == exp_done, exp_done ? "R6 done" : "R7 no done", got_done, exp_done);
    check(got_tmo == !exp_done, exp_done ? "R6 no timeout" : "R7 timeout", got_tmo, !exp_done);
    check(rd_cnt == (exp_done ? k + 2 : MAXP), exp_done ? "R6 read count" : "R7 read count",
          rd_cnt, exp_done ? k + 2 : MAXP);
    nw = (op == 2'd0) ? 4 : 6;
    check(wr_cnt == nw, (op == 2'd0) ? "R4 write count" : "R5 write count", wr_cnt, nw);
    for (int i = 0; i < nw && i < wr_cnt; i++) begin
      check(wa[i] == exp_addr(op, a, i), (op == 2'd0) ? "R4 address" : "R5 address",
            wa[i], exp_addr(op, a, i));
      check(wd[i] == exp_data(op, d, i), (op == 2'd0) ? "R4 data" : "R5 data",
            wd[i], exp_data(op, d, i));
    end
    check(!wp_bad, "R8 wp static", wp_bad, 0);
    if (poke) check(wr_cnt == nw, "R9 start while busy ignored", wr_cnt, nw);
    @(negedge clk);
    check(done == 1'b0 && timeout_err == 1'b0, "R6 one-clock outcome pulse", {done, timeout_err}, 0);
  endtask

  task automatic run_abort(input int wait_reads);
    int lows;
    bit saw_done;
    @(negedge clk);
    timing_on = 0; wr_cnt = 0; rd_cnt = 0; toggles_left = 8;
    req_op = 2'd1; req_addr = 21'h1ABCD; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (wait_reads > 0) begin
      while (rd_cnt < wait_reads) @(negedge clk);
    end else begin
      repeat (9) @(negedge clk);
    end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(flash_rst_n == 1'b0, "R10 reset asserted", flash_rst_n, 0);
    check(flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe, "R10 bus released",
          {flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe}, 4'b1110);
    lows = 1; saw_done = 0;
    while (flash_rst_n == 1'b0 && lows < 100) begin
      @(negedge clk);
      if (done || timeout_err) saw_done = 1;
      if (!flash_rst_n) lows++;
    end
    check(lows == T_RST, "R10 reset width", lows, T_RST);
    check(busy == 1'b0, "R10 idle after reset", busy, 0);
    repeat (30) begin
      @(negedge clk);
      if (done || timeout_err || !flash_we_n || !flash_oe_n) saw_done = 1;
    end
    check(!saw_done, "R10 no outcome after abort", saw_done, 0);
    timing_on = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && timeout_err == 0, "R1 status in reset", {busy, done, timeout_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(flash_ce_n && flash_we_n && flash_oe_n && flash_rst_n && !flash_dq_oe && !busy,
          "R1 bus idle after reset",
          {flash_ce_n, flash_we_n, flash_oe_n, flash_rst_n, flash_dq_oe, busy}, 6'b111100);

    // directed corners
    run_op(2'd0, 21'h1FFFFF, 16'hFFFF, 1'b1, 0, 0);   // fastest completion
    run_op(2'd1, 21'h1FFFFF, 16'h0000, 1'b0, 10, 0);  // exactly at the poll limit
    run_op(2'd2, 21'h0ABCDE, 16'h0000, 1'b1, 11, 0);  // one past the limit
    run_op(2'd0, 21'h012345, 16'hBEEF, 1'b0, 3, 1);   // start while busy

    // reserved opcode
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0;
    req_op = 2'd3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b0, "R11 reserved not accepted", busy, 0);
    repeat (20) @(negedge clk);
    check(wr_cnt == 0 && rd_cnt == 0 && flash_ce_n, "R11 no bus cycle", wr_cnt + rd_cnt, 0);

    run_abort(0);
    run_abort(3);

    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 2));
      run_op(op, 21'($urandom), 16'($urandom), 1'($urandom), int'($urandom_range(0, 13)),
             bit'($urandom_range(0, 3) == 0));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule